// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is the combinational execute stage of a small load-store processor core. It takes two 32-bit register operands, a 16-bit immediate, a 5-bit shift count and a 4-bit operation code. It returns a 32-bit result and three flags. The zero flag drives equal and not-equal branch decisions. The overflow-trap request goes to the exception logic. The carry flag reports unsigned carry-out of an addition. Instruction decode lies outside the block and only presents the operation code and the immediate-select bit.

Addition and subtraction come in three forms. The trapping form raises a trap request on signed overflow. The wrapping form never traps and returns the result modulo 2^32. The saturating form clamps an out-of-range result to the signed extreme. When the immediate is selected it takes the place of operand B. How it is widened depends on the operation: logical operations fill the upper half with zeros, and every other operation copies the immediate's sign bit.

Top module: `int_alu`

## Requirements
- R1: The wrapping add (code 1) returns A+B and the wrapping subtract (code 3) returns A-B, both modulo 2^32, and neither ever raises the trap output.
- R2: The trapping add (code 0) and trapping subtract (code 2) return the wrapped result. They raise the trap output exactly on signed overflow. An add overflows when both operands share a sign and the sum's sign differs from it. A subtract overflows when the operand signs differ and the result's sign differs from A's sign.
- R3: For every code other than 0 and 2 the trap output is 0.
- R4: The saturating add (code 4) and saturating subtract (code 5) return the wrapped result when there is no overflow. On overflow they return 0x7FFFFFFF when A is non-negative and 0x80000000 when A is negative.
- R5: Code 6 returns A AND B, code 7 returns A OR B, and code 8 returns NOT(A OR B), so NOR with a zero B returns NOT A.
- R6: Code 9 returns 1 when A < B as signed numbers, and code 10 returns 1 when A < B as unsigned numbers. Otherwise both return 0.
- R7: Code 11 shifts operand B left and code 12 shifts operand B right by the shift count (0 to 31), and vacated bits are filled with zeros.
- R8: Code 13 returns the 16-bit immediate in bits 31:16 and zeros in bits 15:0, whatever the operands are.
- R9: When the immediate-select input is 1, the widened immediate replaces B and the B input has no effect. Codes 6, 7 and 8 fill bits 31:16 with zeros. All other codes copy immediate bit 15 into bits 31:16.
- R10: The zero flag is 1 exactly when the 32-bit result is zero.
- R11: For the add codes 0, 1 and 4, the carry flag is 1 exactly when the unsigned sum A+B exceeds 2^32-1, which is detected as (NOT A) < B in unsigned terms. For every other code it is 0.
- R12: The unused codes 14 and 15 return a zero result with the carry and trap flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see requirements) |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B (register form) |
| imm_i | input | 16 | Immediate constant |
| use_imm_i | input | 1 | 1 selects the widened immediate in place of B |
| shamt_i | input | 5 | Shift count for the shift codes |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result equals zero |
| ovf_trap_o | output | 1 | Signed-overflow trap request |
| carry_o | output | 1 | Unsigned carry-out of an add |

## Verification
Two flags can be raised by the same operation: a trapping add whose wrapped sum is exactly zero raises both the trap and the zero flag. The bench provokes this with 0x80000000 + 0x80000000, where the carry flag also rises. It checks all three flags against values computed by hand from the overflow and carry rules. The bench also covers a saturating add that both clamps and carries, and confirms that the trap flag stays low for that case.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    parameter int unsigned XLEN  = 32;
    parameter int unsigned IMM_W = 16;
    parameter int unsigned OP_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_TRAP = 4'd0,
        OP_ADD_WRAP = 4'd1,
        OP_SUB_TRAP = 4'd2,
        OP_SUB_WRAP = 4'd3,
        OP_ADD_SAT  = 4'd4,
        OP_SUB_SAT  = 4'd5,
        OP_AND      = 4'd6,
        OP_OR       = 4'd7,
        OP_NOR      = 4'd8,
        OP_SLT      = 4'd9,
        OP_SLTU     = 4'd10,
        OP_SLL      = 4'd11,
        OP_SRL      = 4'd12,
        OP_LUI      = 4'd13
    } alu_op_e;

    typedef enum logic {
        FILL_ZERO = 1'b0,
        FILL_SIGN = 1'b1
    } fill_e;

    // Logical operations widen the constant with zeros, all others with its sign.
    function automatic fill_e fill_for(input alu_op_e op);
        case (op)
            OP_AND, OP_OR, OP_NOR: fill_for = FILL_ZERO;
            default:               fill_for = FILL_SIGN;
        endcase
    endfunction

    function automatic logic is_sub(input alu_op_e op);
        is_sub = (op == OP_SUB_TRAP) || (op == OP_SUB_WRAP) || (op == OP_SUB_SAT);
    endfunction

    function automatic logic is_add(input alu_op_e op);
        is_add = (op == OP_ADD_TRAP) || (op == OP_ADD_WRAP) || (op == OP_ADD_SAT);
    endfunction

endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext
    import int_alu_pkg::*;
#(
    parameter int unsigned W  = XLEN,
    parameter int unsigned IW = IMM_W
) (
    input  logic [IW-1:0] imm_i,
    input  fill_e         fill_i,
    output logic [W-1:0]  ext_o
);
    localparam int unsigned PAD = W - IW;

    logic fill_bit;
    assign fill_bit = (fill_i == FILL_SIGN) ? imm_i[IW-1] : 1'b0;
    assign ext_o    = {{PAD{fill_bit}}, imm_i};
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o,
    output logic         carry_o
);
    logic [W-1:0] b_in;

    // Subtraction is addition of the bitwise inverse plus one.
    assign b_in  = sub_i ? ~b_i : b_i;
    assign sum_o = a_i + b_in + {{(W-1){1'b0}}, sub_i};

    // Overflow only when the effective addends agree in sign and the sum disagrees.
    assign ovf_o = (a_i[W-1] == b_in[W-1]) && (sum_o[W-1] != a_i[W-1]);

    // Unsigned carry of A+B: the sum exceeds the maximum exactly when ~A < B.
    assign carry_o = (~a_i) < b_i;
endmodule

// File: rtl/alu_logic_shift.sv
module alu_logic_shift
    import int_alu_pkg::*;
#(
    parameter int unsigned W  = XLEN,
    parameter int unsigned IW = IMM_W,
    localparam int unsigned SW = $clog2(W)
) (
    input  alu_op_e       op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic [IW-1:0] imm_i,
    input  logic [SW-1:0] shamt_i,
    output logic [W-1:0]  res_o
);
    localparam int unsigned LOW = W - IW;

    logic lt_signed;
    logic lt_unsigned;

    assign lt_signed   = $signed(a_i) < $signed(b_i);
    assign lt_unsigned = a_i < b_i;

    always_comb begin
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_NOR:  res_o = ~(a_i | b_i);
            OP_SLT:  res_o = {{(W-1){1'b0}}, lt_signed};
            OP_SLTU: res_o = {{(W-1){1'b0}}, lt_unsigned};
            OP_SLL:  res_o = b_i << shamt_i;
            OP_SRL:  res_o = b_i >> shamt_i;
            OP_LUI:  res_o = {imm_i, {LOW{1'b0}}};
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int unsigned W  = XLEN,
    parameter int unsigned IW = IMM_W,
    localparam int unsigned SW = $clog2(W)
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [IW-1:0]   imm_i,
    input  logic            use_imm_i,
    input  logic [SW-1:0]   shamt_i,
    output logic [W-1:0]    result_o,
    output logic            zero_o,
    output logic            ovf_trap_o,
    output logic            carry_o
);
    localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

    alu_op_e      op;
    logic [W-1:0] imm_ext;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic         ovf;
    logic         carry;
    logic [W-1:0] ls_res;

    assign op = alu_op_e'(op_i);

    alu_imm_ext #(.W(W), .IW(IW)) u_ext (
        .imm_i  (imm_i),
        .fill_i (fill_for(op)),
        .ext_o  (imm_ext)
    );

    assign b_eff = use_imm_i ? imm_ext : b_i;

    alu_addsub #(.W(W)) u_addsub (
        .a_i     (a_i),
        .b_i     (b_eff),
        .sub_i   (is_sub(op)),
        .sum_o   (sum),
        .ovf_o   (ovf),
        .carry_o (carry)
    );

    alu_logic_shift #(.W(W), .IW(IW)) u_ls (
        .op_i    (op),
        .a_i     (a_i),
        .b_i     (b_eff),
        .imm_i   (imm_i),
        .shamt_i (shamt_i),
        .res_o   (ls_res)
    );

    always_comb begin
        case (op)
            OP_ADD_TRAP, OP_ADD_WRAP,
            OP_SUB_TRAP, OP_SUB_WRAP: result_o = sum;
            OP_ADD_SAT, OP_SUB_SAT:   result_o = ovf ? (a_i[W-1] ? SAT_MIN : SAT_MAX) : sum;
            default:                  result_o = ls_res;
        endcase
    end

    assign zero_o     = (result_o == '0);
    assign ovf_trap_o = ((op == OP_ADD_TRAP) || (op == OP_SUB_TRAP)) && ovf;
    assign carry_o    = is_add(op) && carry;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk (
    input logic [3:0]  op_i,
    input logic [31:0] a_i,
    input logic [31:0] b_i,
    input logic [15:0] imm_i,
    input logic        use_imm_i,
    input logic [4:0]  shamt_i,
    input logic [31:0] result_o,
    input logic        ovf_trap_o,
    input logic        carry_o
);
    always_comb begin
        if (op_i != 4'd0 && op_i != 4'd2)
            AST_TRAP_ONLY_ARITH: assert (!ovf_trap_o); // R3
        if (op_i == 4'd0 && !use_imm_i && (a_i[31] != b_i[31]))
            AST_NO_OVF_MIXED_ADD: assert (!ovf_trap_o); // R2
        if (op_i == 4'd4 && !use_imm_i && !a_i[31] && !b_i[31])
            AST_SAT_STAYS_POS: assert (!result_o[31]); // R4
        if (op_i == 4'd9 || op_i == 4'd10)
            AST_SLT_ONE_BIT: assert (result_o[31:1] == 31'd0); // R6
        if ((op_i == 4'd11 || op_i == 4'd12) && !use_imm_i && shamt_i == 5'd0)
            AST_SHIFT_ZERO_PASS: assert (result_o == b_i); // R7
        if (op_i == 4'd13)
            AST_LUI_LOW_CLEAR: assert (result_o[15:0] == 16'd0 && result_o[31:16] == imm_i); // R8
        if (op_i >= 4'd14)
            AST_UNUSED_SILENT: assert (result_o == 32'd0 && !carry_o); // R12
    end
endmodule

bind int_alu int_alu_chk u_chk (
    .op_i       (op_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .imm_i      (imm_i),
    .use_imm_i  (use_imm_i),
    .shamt_i    (shamt_i),
    .result_o   (result_o),
    .ovf_trap_o (ovf_trap_o),
    .carry_o    (carry_o)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic        ui;
        logic [4:0]  sh;
        logic [31:0] res;
        logic        z;
        logic        v;
        logic        c;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 33;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  32'h00000005, 32'h00000007, 16'h0000, 1'b0, 5'd0,  32'h0000000C, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{4'd0,  32'h7FFFFFFF, 32'h00000001, 16'h0000, 1'b0, 5'd0,  32'h80000000, 1'b0, 1'b1, 1'b0, 4'd2},  // R2
        '{4'd0,  32'h80000000, 32'h80000000, 16'h0000, 1'b0, 5'd0,  32'h00000000, 1'b1, 1'b1, 1'b1, 4'd10}, // R10 R11
        '{4'd1,  32'h7FFFFFFF, 32'h00000001, 16'h0000, 1'b0, 5'd0,  32'h80000000, 1'b0, 1'b0, 1'b0, 4'd1},  // R1
        '{4'd1,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 1'b0, 5'd0,  32'h00000000, 1'b1, 1'b0, 1'b1, 4'd11}, // R11
        '{4'd2,  32'h80000000, 32'h00000001, 16'h0000, 1'b0, 5'd0,  32'h7FFFFFFF, 1'b0, 1'b1, 1'b0, 4'd2},  // R2
        '{4'd2,  32'h00000005, 32'h00000005, 16'h0000, 1'b0, 5'd0,  32'h00000000, 1'b1, 1'b0, 1'b0, 4'd10}, // R10
        '{4'd2,  32'hFFFFFFFF, 32'h7FFFFFFF, 16'h0000, 1'b0, 5'd0,  32'h80000000, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{4'd3,  32'h00000000, 32'h00000001, 16'h0000, 1'b0, 5'd0,  32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 4'd1},  // R1
        '{4'd4,  32'h7FFFFFF0, 32'h00000100, 16'h0000, 1'b0, 5'd0,  32'h7FFFFFFF, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{4'd4,  32'h80000000, 32'hFFFFFFFF, 16'h0000, 1'b0, 5'd0,  32'h80000000, 1'b0, 1'b0, 1'b1, 4'd4},  // R4
        '{4'd5,  32'h80000000, 32'h00000001, 16'h0000, 1'b0, 5'd0,  32'h80000000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{4'd5,  32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0000, 1'b0, 5'd0,  32'h7FFFFFFF, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{4'd4,  32'h00000003, 32'h00000004, 16'h0000, 1'b0, 5'd0,  32'h00000007, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{4'd6,  32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 1'b0, 5'd0,  32'hF000F000, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
        '{4'd7,  32'h12340000, 32'h00005678, 16'h0000, 1'b0, 5'd0,  32'h12345678, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
        '{4'd8,  32'hA5A5A5A5, 32'h00000000, 16'h0000, 1'b0, 5'd0,  32'h5A5A5A5A, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
        '{4'd9,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 1'b0, 5'd0,  32'h00000001, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
        '{4'd10, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 1'b0, 5'd0,  32'h00000000, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
        '{4'd9,  32'h00000005, 32'h00000005, 16'h0000, 1'b0, 5'd0,  32'h00000000, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
        '{4'd11, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 1'b0, 5'd31, 32'h80000000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{4'd12, 32'hFFFFFFFF, 32'h80000000, 16'h0000, 1'b0, 5'd31, 32'h00000001, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{4'd11, 32'h00000000, 32'hDEADBEEF, 16'h0000, 1'b0, 5'd0,  32'hDEADBEEF, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{4'd12, 32'h00000000, 32'hF0000000, 16'h0000, 1'b0, 5'd4,  32'h0F000000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{4'd13, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h1234, 1'b0, 5'd0,  32'h12340000, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
        '{4'd0,  32'h00000010, 32'h00000000, 16'hFFFF, 1'b1, 5'd0,  32'h0000000F, 1'b0, 1'b0, 1'b1, 4'd9},  // R9
        '{4'd7,  32'h00000000, 32'h00000000, 16'h8000, 1'b1, 5'd0,  32'h00008000, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
        '{4'd6,  32'hFFFFFFFF, 32'h00000000, 16'hFFFF, 1'b1, 5'd0,  32'h0000FFFF, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
        '{4'd9,  32'h00000000, 32'h00000000, 16'hFFFF, 1'b1, 5'd0,  32'h00000000, 1'b1, 1'b0, 1'b0, 4'd9},  // R9
        '{4'd10, 32'h00000000, 32'h00000000, 16'h8000, 1'b1, 5'd0,  32'h00000001, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
        '{4'd0,  32'h00000001, 32'h00000100, 16'h0001, 1'b1, 5'd0,  32'h00000002, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 B ignored
        '{4'd15, 32'h00000005, 32'h00000005, 16'h0000, 1'b0, 5'd0,  32'h00000000, 1'b1, 1'b0, 1'b0, 4'd12}, // R12
        '{4'd2,  32'h00000000, 32'h00000000, 16'h8000, 1'b1, 5'd0,  32'h00008000, 1'b0, 1'b0, 1'b0, 4'd9}   // R9
    };

    logic        clk = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [15:0] imm_i = '0;
    logic        use_imm_i = 1'b0;
    logic [4:0]  shamt_i = '0;
    logic [31:0] result_o;
    logic        zero_o;
    logic        ovf_trap_o;
    logic        carry_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    int_alu u_int_alu (
        .op_i       (op_i),
        .a_i        (a_i),
        .b_i        (b_i),
        .imm_i      (imm_i),
        .use_imm_i  (use_imm_i),
        .shamt_i    (shamt_i),
        .result_o   (result_o),
        .zero_o     (zero_o),
        .ovf_trap_o (ovf_trap_o),
        .carry_o    (carry_o)
    );

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic ui, input logic [4:0] sh);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; imm_i = imm; use_imm_i = ui; shamt_i = sh;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got res=%h z=%b v=%b c=%b, want res=%h z=%b v=%b c=%b",
                     tag, act[34:3], act[2], act[1], act[0], exp[34:3], exp[2], exp[1], exp[0]);
        end
    endtask

    initial begin
        // Initial state with all inputs zero: wrapping-free add of 0+0 (R10)
        apply(4'd0, 32'd0, 32'd0, 16'd0, 1'b0, 5'd0);
        check("R10 idle", {result_o, zero_o, ovf_trap_o, carry_o}, {32'd0, 1'b1, 1'b0, 1'b0});

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].ui, VECS[i].sh);
            check($sformatf("R%0d vec%0d", VECS[i].req, i),
                  {result_o, zero_o, ovf_trap_o, carry_o},
                  {VECS[i].res, VECS[i].z, VECS[i].v, VECS[i].c});
        end

        // R7: every shift count on a single bit, both directions
        for (int s = 0; s < 32; s++) begin
            apply(4'd11, 32'd0, 32'd1, 16'd0, 1'b0, 5'(s));
            check("R7 sll sweep", {result_o, zero_o, ovf_trap_o, carry_o},
                  {32'd1 << s, 1'b0, 1'b0, 1'b0});
            apply(4'd12, 32'd0, 32'h80000000, 16'd0, 1'b0, 5'(s));
            check("R7 srl sweep", {result_o, zero_o, ovf_trap_o, carry_o},
                  {32'h80000000 >> s, 1'b0, 1'b0, 1'b0});
        end

        // R3: overflow-prone operands on every non-trapping code keep the trap low
        for (int o = 1; o < 16; o++) begin
            if (o != 2) begin
                apply(4'(o), 32'h7FFFFFFF, 32'h80000001, 16'd0, 1'b0, 5'd0);
                total++;
                if (ovf_trap_o !== 1'b0) begin
                    bad++;
                    $display("FAIL R3 op=%0d: got trap=%b, want trap=0", o, ovf_trap_o);
                end
            end
        end

        // R5: NOR with zero inverts A
        apply(4'd8, 32'h0000FFFF, 32'd0, 16'd0, 1'b0, 5'd0);
        check("R5 not", {result_o, zero_o, ovf_trap_o, carry_o}, {32'hFFFF0000, 1'b0, 1'b0, 1'b0});
        apply(4'd8, 32'hFFFFFFFF, 32'd0, 16'd0, 1'b0, 5'd0);
        check("R5 not zero", {result_o, zero_o, ovf_trap_o, carry_o}, {32'h00000000, 1'b1, 1'b0, 1'b0});

        // R11: subtract never reports carry
        apply(4'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'd0, 1'b0, 5'd0);
        check("R11 sub carry", {result_o, zero_o, ovf_trap_o, carry_o}, {32'd0, 1'b1, 1'b0, 1'b0});

        // R12: the other unused code
        apply(4'd14, 32'hFFFFFFFF, 32'h00000001, 16'hFFFF, 1'b1, 5'd3);
        check("R12 code14", {result_o, zero_o, ovf_trap_o, carry_o}, {32'd0, 1'b1, 1'b0, 1'b0});

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: got timeout, want completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule